// File: doc/BRIEF.md
# Error Logging Bank Status Word

This block is one error-logging bank. A monitored structure reports error events to it, and the bank condenses them into a single 64-bit status word that software reads. Each event carries a valid strobe, an uncorrected flag, a context-corrupt flag, address-valid and misc-valid flags, signalling and action-required flags, a firmware-updated flag, a 16-bit error code and a 16-bit model-specific code. The first event into an empty bank is logged in full. Later events set the overflow flag, and an uncorrected error may replace a logged corrected one.

Beside the logged record, the bank keeps a 15-bit corrected-error counter. Its low 14 bits saturate, and its top bit is a sticky overflow flag. The bank also keeps a green/yellow health state, which turns yellow when the count reaches a programmable threshold. Four static capability inputs decide which fields read as architectural and which read as zero.

Software clears the whole word by writing zero. A separate strobe clears only the counter and the health state. A clear and a new event in the same cycle are applied in order: the clear first, then the event.

Top module: `err_bank_status`

## Requirements
- R1: An event into an empty bank (bit 63 = 0) logs it: bit 63 = 1, bit 62 = 0, bit 61 uncorrected, bit 60 the `rpt_en` level at capture, bit 59 misc-valid, bit 58 address-valid, bit 57 context-corrupt, bits 31:16 model code, bits 15:0 error code, bits 36:32 zero. Reset leaves the word all zero.
- R2: An event that arrives while bit 63 is set sets bit 62 (overflow), which stays set until the word is cleared.
- R3: While bit 63 is set, an uncorrected event replaces a logged corrected record. A corrected event never replaces a logged uncorrected record.
- R4: With `cap_cnt` = 1, bits 51:38 count the corrected events the bank observes, whether or not they are logged. Uncorrected events do not count.
- R5: The count saturates at 14'h3FFF. An increment attempted at saturation sets bit 52, which stays set until a counter clear.
- R6: With `cap_thr` = 1, `cap_cnt` = 1 and a valid corrected record, bits 54:53 read 01 (green) while the count is below `thr_lvl` and 10 (yellow) once an increment has made the count reach or exceed `thr_lvl`. With `cap_cnt` = 0 they read 00. They never read 11.
- R7: Bits 54:53 read 00 when the logged record is uncorrected, when `cap_thr` = 0, or when bit 63 = 0.
- R8: Bits 56 (signalling) and 55 (action-required) show the logged flags only when `cap_thr` = 1 and `cap_rec` = 1. Otherwise they read zero.
- R9: Bit 37 shows the logged firmware-updated flag only when `cap_fw` = 1. Otherwise it reads zero.
- R10: With `cap_cnt` = 0, bits 52:38 read zero and corrected events do not advance the counter.
- R11: A software write of zero clears the whole word, including the counter and the health state, in one cycle. A write of any non-zero value changes nothing.
- R12: A pulse on `sw_cnt_clr` zeroes bits 52:38 and returns the health state to green, and leaves every other field unchanged.
- R13: A clear (zero write or `sw_cnt_clr`) in the same cycle as an event is applied first, and the event is then applied on the cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_cnt | input | 1 | Corrected-error counter capability |
| cap_thr | input | 1 | Threshold-status capability |
| cap_rec | input | 1 | Recoverable-signalling capability |
| cap_fw | input | 1 | Firmware-updated indicator capability |
| rpt_en | input | 1 | Reporting-enabled level, logged into bit 60 |
| thr_lvl | input | 14 | Yellow threshold on the count |
| evt_vld | input | 1 | Error event strobe |
| evt_uc | input | 1 | Event is uncorrected |
| evt_pcc | input | 1 | Processor context corrupted |
| evt_addrv | input | 1 | Address companion valid |
| evt_miscv | input | 1 | Misc companion valid |
| evt_sig | input | 1 | Signalling flag |
| evt_ar | input | 1 | Action-required flag |
| evt_fw | input | 1 | Firmware-updated flag |
| evt_code | input | 16 | Error code |
| evt_model | input | 16 | Model-specific code |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 64 | Software write data |
| sw_cnt_clr | input | 1 | Counter clear strobe |
| status | output | 64 | Status word |

## Verification
The functions that collide are the software clears and event capture. A zero write or a counter-clear strobe can land in the same cycle as a corrected event. The bench drives both in one clock. It then checks that the word holds a fresh record with overflow low and a count of one after a zero write, and that a counter clear leaves the overflow flag and the record alone while the count restarts at one. The saturation edge is reached by 16383 back-to-back corrected events, followed by single extra increments.

// File: rtl/err_bank_pkg.sv
package err_bank_pkg;
  parameter int unsigned CODE_W = 16;
  parameter int unsigned CNT_W  = 15;
  localparam int unsigned LOW_W = CNT_W - 1;
  localparam int unsigned WORD_W = 64;

  localparam int unsigned B_VAL   = 63;
  localparam int unsigned B_OVR   = 62;
  localparam int unsigned B_UC    = 61;
  localparam int unsigned B_EN    = 60;
  localparam int unsigned B_MISCV = 59;
  localparam int unsigned B_ADDRV = 58;
  localparam int unsigned B_PCC   = 57;
  localparam int unsigned B_SIG   = 56;
  localparam int unsigned B_AR    = 55;
  localparam int unsigned B_TS_LO = 53;
  localparam int unsigned B_CNT_LO = 38;
  localparam int unsigned B_CNT_HI = B_CNT_LO + CNT_W - 1;
  localparam int unsigned B_FW    = 37;
  localparam int unsigned B_MOD_LO = 16;

  typedef enum logic [1:0] {
    TRK_NONE   = 2'b00,
    TRK_GREEN  = 2'b01,
    TRK_YELLOW = 2'b10
  } trk_e;

  typedef struct packed {
    logic              uc;
    logic              pcc;
    logic              addrv;
    logic              miscv;
    logic              sig;
    logic              ar;
    logic              fw;
    logic              en;
    logic [CODE_W-1:0] model;
    logic [CODE_W-1:0] code;
  } rec_t;
endpackage

// File: rtl/err_bank_ctr.sv
module err_bank_ctr
  import err_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic [LOW_W-1:0] thr,
  output logic [LOW_W-1:0] cnt,
  output logic             ovf,
  output logic             yel
);
  localparam logic [LOW_W-1:0] CNT_MAX = {LOW_W{1'b1}};

  logic [LOW_W-1:0] cnt_d;
  logic             ovf_d;
  logic             yel_d;

  always_comb begin
    cnt_d = clr ? '0 : cnt;
    ovf_d = clr ? 1'b0 : ovf;
    yel_d = clr ? 1'b0 : yel;
    if (inc) begin
      if (cnt_d == CNT_MAX) begin
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_d + 1'b1;
      end
      if (cnt_d >= thr) begin
        yel_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
      yel <= 1'b0;
    end else if (inc || clr) begin
      cnt <= cnt_d;
      ovf <= ovf_d;
      yel <= yel_d;
    end
  end
endmodule

// File: rtl/err_bank_log.sv
module err_bank_log
  import err_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_vld,
  input  rec_t evt,
  input  logic clr,
  output logic val,
  output logic ovr,
  output rec_t rec
);
  logic val_d;
  logic ovr_d;
  rec_t rec_d;

  always_comb begin
    val_d = clr ? 1'b0 : val;
    ovr_d = clr ? 1'b0 : ovr;
    rec_d = clr ? '0 : rec;
    if (evt_vld) begin
      if (!val_d) begin
        val_d = 1'b1;
        ovr_d = 1'b0;
        rec_d = evt;
      end else begin
        ovr_d = 1'b1;
        if (evt.uc && !rec_d.uc) begin
          rec_d = evt;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= 1'b0;
      ovr <= 1'b0;
      rec <= '0;
    end else if (evt_vld || clr) begin
      val <= val_d;
      ovr <= ovr_d;
      rec <= rec_d;
    end
  end
endmodule

// File: rtl/err_bank_status.sv
module err_bank_status
  import err_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_cnt,
  input  logic              cap_thr,
  input  logic              cap_rec,
  input  logic              cap_fw,
  input  logic              rpt_en,
  input  logic [LOW_W-1:0]  thr_lvl,
  input  logic              evt_vld,
  input  logic              evt_uc,
  input  logic              evt_pcc,
  input  logic              evt_addrv,
  input  logic              evt_miscv,
  input  logic              evt_sig,
  input  logic              evt_ar,
  input  logic              evt_fw,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [CODE_W-1:0] evt_model,
  input  logic              sw_wr,
  input  logic [WORD_W-1:0] sw_wdata,
  input  logic              sw_cnt_clr,
  output logic [WORD_W-1:0] status
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic             zero_wr;
  logic             ctr_inc;
  logic             ctr_clr;
  rec_t             evt_rec;
  logic             log_val;
  logic             log_ovr;
  rec_t             log_rec;
  logic [LOW_W-1:0] ctr_cnt;
  logic             ctr_ovf;
  logic             ctr_yel;
  trk_e             trk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  assign zero_wr = sw_wr && (sw_wdata == '0);
  assign ctr_inc = evt_vld && !evt_uc && cap_cnt;
  assign ctr_clr = zero_wr || sw_cnt_clr;

  always_comb begin
    evt_rec       = '0;
    evt_rec.uc    = evt_uc;
    evt_rec.pcc   = evt_pcc;
    evt_rec.addrv = evt_addrv;
    evt_rec.miscv = evt_miscv;
    evt_rec.sig   = evt_sig;
    evt_rec.ar    = evt_ar;
    evt_rec.fw    = evt_fw;
    evt_rec.en    = rpt_en;
    evt_rec.model = evt_model;
    evt_rec.code  = evt_code;
  end

  err_bank_log u_log (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .evt_vld (evt_vld),
    .evt     (evt_rec),
    .clr     (zero_wr),
    .val     (log_val),
    .ovr     (log_ovr),
    .rec     (log_rec)
  );

  err_bank_ctr u_ctr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .inc   (ctr_inc),
    .clr   (ctr_clr),
    .thr   (thr_lvl),
    .cnt   (ctr_cnt),
    .ovf   (ctr_ovf),
    .yel   (ctr_yel)
  );

  always_comb begin
    trk = TRK_NONE;
    if (cap_thr && cap_cnt && log_val && !log_rec.uc) begin
      trk = ctr_yel ? TRK_YELLOW : TRK_GREEN;
    end
  end

  always_comb begin
    status          = '0;
    status[B_VAL]   = log_val;
    status[B_OVR]   = log_ovr;
    status[B_UC]    = log_rec.uc;
    status[B_EN]    = log_rec.en;
    status[B_MISCV] = log_rec.miscv;
    status[B_ADDRV] = log_rec.addrv;
    status[B_PCC]   = log_rec.pcc;
    if (cap_thr && cap_rec) begin
      status[B_SIG] = log_rec.sig;
      status[B_AR]  = log_rec.ar;
    end
    status[B_TS_LO+1:B_TS_LO] = trk;
    if (cap_cnt) begin
      status[B_CNT_HI]                = ctr_ovf;
      status[B_CNT_HI-1:B_CNT_LO]     = ctr_cnt;
    end
    if (cap_fw) begin
      status[B_FW] = log_rec.fw;
    end
    status[B_MOD_LO+CODE_W-1:B_MOD_LO] = log_rec.model;
    status[CODE_W-1:0]                 = log_rec.code;
  end
endmodule

// File: rtl/err_bank_status_chk.sv
module err_bank_status_chk
  import err_bank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cap_cnt,
  input logic              cap_thr,
  input logic              evt_vld,
  input logic              evt_uc,
  input logic              sw_wr,
  input logic [WORD_W-1:0] sw_wdata,
  input logic              sw_cnt_clr,
  input logic [WORD_W-1:0] status
);
  logic zw;
  assign zw = sw_wr && (sw_wdata == '0);

  always_comb begin
    if (rst_n) begin
      assert_no_reserved_trk_R6: assert (status[B_TS_LO+1:B_TS_LO] != 2'b11);
      assert_cnt_masked_R10: assert (cap_cnt || status[B_CNT_HI:B_CNT_LO] == '0);
      assert_uc_no_trk_R7: assert (!status[B_UC] || status[B_TS_LO+1:B_TS_LO] == 2'b00);
    end
  end

  assert_overflow_on_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && status[B_VAL] && !zw) |=> status[B_OVR]);

  assert_uc_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && !evt_uc && status[B_VAL] && status[B_UC] && !zw)
    |=> ($stable(status[CODE_W-1:0]) && status[B_UC]));

  assert_sticky_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_cnt && status[B_CNT_HI] && !zw && !sw_cnt_clr) |=> (status[B_CNT_HI] || !cap_cnt));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_cnt && evt_vld && !evt_uc && !zw && !sw_cnt_clr && !status[B_CNT_HI]
     && status[B_CNT_HI-1:B_CNT_LO] != {LOW_W{1'b1}})
    |=> (!cap_cnt ||
         status[B_CNT_HI-1:B_CNT_LO] == $past(status[B_CNT_HI-1:B_CNT_LO]) + 1'b1));

  assert_zero_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (zw && !evt_vld) |=> (status == '0));

  assert_cnt_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_cnt_clr && !evt_vld) |=> (status[B_CNT_HI:B_CNT_LO] == '0));
endmodule

bind err_bank_status err_bank_status_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cap_cnt    (cap_cnt),
  .cap_thr    (cap_thr),
  .evt_vld    (evt_vld),
  .evt_uc     (evt_uc),
  .sw_wr      (sw_wr),
  .sw_wdata   (sw_wdata),
  .sw_cnt_clr (sw_cnt_clr),
  .status     (status)
);

// File: tb/err_bank_status_tb_top.sv
`timescale 1ns/1ps
module err_bank_status_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cap_cnt, cap_thr, cap_rec, cap_fw, rpt_en;
  logic [13:0] thr_lvl;
  logic        evt_vld, evt_uc, evt_pcc, evt_addrv, evt_miscv, evt_sig, evt_ar, evt_fw;
  logic [15:0] evt_code, evt_model;
  logic        sw_wr;
  logic [63:0] sw_wdata;
  logic        sw_cnt_clr;
  logic [63:0] status;

  int n_tests = 0;
  int n_fail  = 0;

  err_bank_status dut_i (
    .clk(clk), .rst_n(rst_n), .cap_cnt(cap_cnt), .cap_thr(cap_thr),
    .cap_rec(cap_rec), .cap_fw(cap_fw), .rpt_en(rpt_en), .thr_lvl(thr_lvl),
    .evt_vld(evt_vld), .evt_uc(evt_uc), .evt_pcc(evt_pcc), .evt_addrv(evt_addrv),
    .evt_miscv(evt_miscv), .evt_sig(evt_sig), .evt_ar(evt_ar), .evt_fw(evt_fw),
    .evt_code(evt_code), .evt_model(evt_model), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_cnt_clr(sw_cnt_clr), .status(status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        pre_clr;
    logic        uc;
    logic [15:0] code;
    logic        e_ovr;
    logic        e_uc;
    logic [15:0] e_code;
    logic [13:0] e_cnt;
    logic [1:0]  e_ts;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0, 1'b0, 16'h00A1, 1'b0, 1'b0, 16'h00A1, 14'd1, 2'b01},
    '{1'b0, 1'b0, 16'h00B2, 1'b1, 1'b0, 16'h00A1, 14'd2, 2'b01},
    '{1'b0, 1'b1, 16'h00C3, 1'b1, 1'b1, 16'h00C3, 14'd2, 2'b00},
    '{1'b0, 1'b0, 16'h00D4, 1'b1, 1'b1, 16'h00C3, 14'd3, 2'b00},
    '{1'b1, 1'b0, 16'h0055, 1'b0, 1'b0, 16'h0055, 14'd1, 2'b01},
    '{1'b0, 1'b0, 16'h0066, 1'b1, 1'b0, 16'h0055, 14'd2, 2'b01},
    '{1'b0, 1'b0, 16'h0077, 1'b1, 1'b0, 16'h0055, 14'd3, 2'b10},
    '{1'b0, 1'b1, 16'h0088, 1'b1, 1'b1, 16'h0088, 14'd3, 2'b00}
  };

  function automatic logic [63:0] mk(
    logic val, logic ovr, logic uc, logic en, logic miscv, logic addrv, logic pcc,
    logic sig, logic ar, logic [1:0] ts, logic ovf, logic [13:0] cnt, logic fw,
    logic [15:0] model, logic [15:0] code);
    return {val, ovr, uc, en, miscv, addrv, pcc, sig, ar, ts, ovf, cnt, fw, 5'b0, model, code};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic evt(logic uc, logic [15:0] code, logic flags);
    @(negedge clk);
    evt_vld = 1'b1; evt_uc = uc; evt_code = code; evt_model = ~code;
    evt_pcc = flags; evt_addrv = flags; evt_miscv = flags;
    evt_sig = flags; evt_ar = flags; evt_fw = flags;
    @(negedge clk);
    evt_vld = 1'b0; evt_pcc = 0; evt_addrv = 0; evt_miscv = 0;
    evt_sig = 0; evt_ar = 0; evt_fw = 0; evt_uc = 0;
  endtask

  task automatic wr(logic [63:0] d);
    @(negedge clk);
    sw_wr = 1'b1; sw_wdata = d;
    @(negedge clk);
    sw_wr = 1'b0; sw_wdata = '0;
  endtask

  task automatic cnt_clr();
    @(negedge clk);
    sw_cnt_clr = 1'b1;
    @(negedge clk);
    sw_cnt_clr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] snap;
    rst_n = 1'b0;
    cap_cnt = 1; cap_thr = 1; cap_rec = 1; cap_fw = 1; rpt_en = 1; thr_lvl = 14'd3;
    evt_vld = 0; evt_uc = 0; evt_pcc = 0; evt_addrv = 0; evt_miscv = 0;
    evt_sig = 0; evt_ar = 0; evt_fw = 0; evt_code = '0; evt_model = '0;
    sw_wr = 0; sw_wdata = '0; sw_cnt_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset", status, 64'h0);

    // Table walk: R1 R2 R3 R4 R6 R7 R11
    foreach (TBL[i]) begin
      if (TBL[i].pre_clr) wr(64'h0);
      evt(TBL[i].uc, TBL[i].code, 1'b0);
      check($sformatf("R2/R3/R4/R6 row %0d", i), status,
            mk(1'b1, TBL[i].e_ovr, TBL[i].e_uc, 1'b1, 0, 0, 0, 0, 0, TBL[i].e_ts,
               1'b0, TBL[i].e_cnt, 1'b0, ~TBL[i].e_code, TBL[i].e_code));
    end

    // R11: non-zero write ignored, zero write clears
    snap = status;
    wr(64'hFFFF_0000_1234_5678);
    check("R11 nonzero write ignored", status, snap);
    wr(64'h0);
    check("R11 zero write clears", status, 64'h0);

    // R1 R8 R9 R7: all flags, capability masking
    evt(1'b1, 16'hBEEF, 1'b1);
    check("R1 flags captured", status,
          mk(1, 0, 1, 1, 1, 1, 1, 1, 1, 2'b00, 0, 14'd0, 1, 16'h4110, 16'hBEEF));
    cap_rec = 0; #1;
    check("R8 no recoverable cap", status,
          mk(1, 0, 1, 1, 1, 1, 1, 0, 0, 2'b00, 0, 14'd0, 1, 16'h4110, 16'hBEEF));
    cap_rec = 1; cap_thr = 0; #1;
    check("R8 no threshold cap", status,
          mk(1, 0, 1, 1, 1, 1, 1, 0, 0, 2'b00, 0, 14'd0, 1, 16'h4110, 16'hBEEF));
    cap_thr = 1; cap_fw = 0; #1;
    check("R9 no firmware cap", status,
          mk(1, 0, 1, 1, 1, 1, 1, 1, 1, 2'b00, 0, 14'd0, 0, 16'h4110, 16'hBEEF));
    cap_fw = 1;

    // R7: corrected record but no threshold capability
    wr(64'h0);
    evt(1'b0, 16'h0010, 1'b0);
    cap_thr = 0; #1;
    check("R7 threshold cap off", status[54:53], 64'h0);
    cap_thr = 1; #1;
    check("R6 green", status[54:53], 64'h1);

    // R12: counter clear leaves rest
    evt(1'b0, 16'h0011, 1'b0);
    evt(1'b0, 16'h0012, 1'b0);
    check("R6 yellow at threshold", status[54:53], 64'h2);
    cnt_clr();
    check("R12 counter clear", status,
          mk(1, 1, 0, 1, 0, 0, 0, 0, 0, 2'b01, 0, 14'd0, 0, 16'hFFEF, 16'h0010));

    // R13: zero write and event same cycle
    @(negedge clk);
    sw_wr = 1; sw_wdata = '0; evt_vld = 1; evt_uc = 0; evt_code = 16'h0099; evt_model = 16'hFF66;
    @(negedge clk);
    sw_wr = 0; evt_vld = 0;
    check("R13 zero write with event", status,
          mk(1, 0, 0, 1, 0, 0, 0, 0, 0, 2'b01, 0, 14'd1, 0, 16'hFF66, 16'h0099));
    evt(1'b0, 16'h00A0, 1'b0);
    @(negedge clk);
    sw_cnt_clr = 1; evt_vld = 1; evt_uc = 0; evt_code = 16'h00AA; evt_model = 16'hFF55;
    @(negedge clk);
    sw_cnt_clr = 0; evt_vld = 0;
    check("R13 counter clear with event", status,
          mk(1, 1, 0, 1, 0, 0, 0, 0, 0, 2'b01, 0, 14'd1, 0, 16'hFF66, 16'h0099));

    // R10: counter absent
    wr(64'h0);
    cap_cnt = 0;
    evt(1'b0, 16'h0020, 1'b0);
    evt(1'b0, 16'h0021, 1'b0);
    check("R10 count field masked", status[52:38], 64'h0);
    check("R6 no counter gives no tracking", status[54:53], 64'h0);
    cap_cnt = 1; #1;
    check("R10 counter did not advance", status[53:38], 64'h1 << 15);

    // R5: saturation and sticky overflow
    wr(64'h0);
    @(negedge clk);
    evt_vld = 1; evt_uc = 0; evt_code = 16'h0001; evt_model = 16'hFFFE;
    repeat (16383) @(negedge clk);
    evt_vld = 0;
    check("R5 count at max", status[52:38], {49'h0, 1'b0, 14'h3FFF});
    evt(1'b0, 16'h0002, 1'b0);
    check("R5 overflow sets", status[52:38], {49'h0, 1'b1, 14'h3FFF});
    evt(1'b0, 16'h0003, 1'b0);
    check("R5 overflow sticky", status[54:38], {47'h0, 2'b10, 1'b1, 14'h3FFF});
    cnt_clr();
    check("R5 clear after overflow", status[54:38], {47'h0, 2'b01, 1'b0, 14'h0});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule